// File: doc/BRIEF.md
# Divider Setting Search Engine

This block takes a parent clock rate and a requested output rate. It finds the pair of small divider codes (M, N) whose resulting rate is the largest one that does not exceed the request. The candidate rate for a code pair comes from a fixed chain of truncating integer steps:

- the parent is divided by a fixed pre-divider,
- the result is divided by a decimal factor of ten,
- that is shifted right by N,
- and finally divided by M plus a fixed offset.

The engine tries every code pair in a fixed order. It keeps the best qualifying candidate and signals completion with a one-cycle pulse. All divisions share one restoring divider that produces one quotient bit per clock. A full search therefore takes a few thousand cycles. A zero divisor is reported on an error output and does not stall the engine.

The block is used by a clock-configuration controller. The controller presents the operands, pulses start, and reads the codes and the rate when done rises. Writing the codes into a register bank and generating the clock both happen outside this block.

Top module: `rate_search_engine`

## Requirements
- R1: Every candidate rate equals ((((parent / prediv) / 10) >> N) / (M + m_offset)), each step an unsigned truncating integer operation done in exactly this order.
- R2: Codes are visited with M as the outer loop and N as the inner loop, each running from 0 to 7, for 64 candidates per search.
- R3: A candidate whose rate is greater than the requested rate is never chosen, and the reported rate never exceeds the request.
- R4: The best result starts as rate 0 with M = 0 and N = 0. A candidate replaces it only when its distance to the request is strictly smaller, so on equal rates the earlier code pair in visiting order is kept.
- R5: When no candidate qualifies (including a request of 0, or a request below every reachable nonzero rate), the result is rate 0, M = 0, N = 0.
- R6: Start is accepted only while idle. All four operands are captured on the accepted start. A start pulse or an operand change during a search has no effect on that search's result and produces no extra done pulse.
- R7: done_o is high for exactly one cycle after the last candidate is evaluated. m_code_o, n_code_o and rate_o hold that result until the next accepted start.
- R8: A pre-divider of 0 ends the search at once with err_o high and a result of rate 0, M = 0, N = 0.
- R9: With an M offset of 0, the candidates with M = 0 are skipped (they have a zero divisor). err_o goes high and the remaining candidates are still searched normally.
- R10: err_o is low at done whenever the pre-divider and the M offset are both nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| parent_rate_i | input | 32 | Parent clock rate |
| target_rate_i | input | 32 | Requested output rate |
| prediv_i | input | 8 | Fixed pre-divider |
| m_offset_i | input | 8 | Offset added to the M code to form the last divisor |
| m_code_o | output | 3 | Chosen M code |
| n_code_o | output | 3 | Chosen N code |
| rate_o | output | 32 | Rate of the chosen codes |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | A zero divisor was met during the search |

## Verification
A wrong internal state shows up at the ports at the single done pulse of the search where it happens:

- A corrupted divider step or a wrong shift gives a rate_o that differs from the arithmetic model.
- A wrong loop order or a non-strict comparison flips the codes in tie cases, even when the rate still matches.
- A capture or state fault makes done_o pulse early, pulse twice, or follow a start issued mid-search.

Each result is therefore compared field by field with a behavioural model of the whole search. The cases include ties, requests below the smallest reachable rate, and both zero-divisor conditions.

// File: rtl/rate_search_pkg.sv
package rate_search_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_PRE,
        PH_DEC,
        PH_CAND
    } eng_phase_e;

endpackage

// File: rtl/rse_divider.sv
module rse_divider #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         go_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         done_o,
    output logic         dz_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic         busy;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] dvs;
        logic [W-1:0] dvd;
        logic         done;
        logic         dz;
    } div_regs_t;

    div_regs_t div_d, div_q;
    logic [W:0] trial;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.rem, div_q.quo[W-1]};
        if (go_i && !div_q.busy) begin
            div_d.dvd = dvd_i;
            div_d.dvs = dvs_i;
            div_d.rem = '0;
            div_d.cnt = '0;
            if (dvs_i == '0) begin
                div_d.dz   = 1'b1;
                div_d.done = 1'b1;
                div_d.quo  = '0;
            end else begin
                div_d.dz   = 1'b0;
                div_d.busy = 1'b1;
                div_d.quo  = dvd_i;
            end
        end else if (div_q.busy) begin
            if (trial >= {1'b0, div_q.dvs}) begin
                div_d.rem = W'(trial - {1'b0, div_q.dvs});
                div_d.quo = {div_q.quo[W-2:0], 1'b1};
            end else begin
                div_d.rem = trial[W-1:0];
                div_d.quo = {div_q.quo[W-2:0], 1'b0};
            end
            div_d.cnt = div_q.cnt + 1'b1;
            if (div_q.cnt == LAST) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assign done_o = div_q.done;
    assign dz_o   = div_q.dz;
    assign quo_o  = div_q.quo;

    logic [2*W-1:0] chk_prod;
    assign chk_prod = {{W{1'b0}}, div_q.quo} * {{W{1'b0}}, div_q.dvs};

    assert_quotient_exact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !dz_o) |-> (chk_prod <= {{W{1'b0}}, div_q.dvd}) &&
                              (({{W{1'b0}}, div_q.dvd} - chk_prod) < {{W{1'b0}}, div_q.dvs}));

    assert_zero_divisor_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && dz_o) |-> (div_q.dvs == '0));

endmodule

// File: rtl/rse_best_keeper.sv
module rse_best_keeper #(
    parameter int RATE_W = 32,
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [RATE_W-1:0] target_i,
    input  logic [RATE_W-1:0] cand_rate_i,
    input  logic [CODE_W-1:0] cand_m_i,
    input  logic [CODE_W-1:0] cand_n_i,
    output logic [RATE_W-1:0] best_rate_o,
    output logic [CODE_W-1:0] best_m_o,
    output logic [CODE_W-1:0] best_n_o
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CODE_W-1:0] m;
        logic [CODE_W-1:0] n;
    } best_t;

    best_t best_d, best_q;
    logic              fits;
    logic [RATE_W-1:0] dist_cand, dist_best;

    always_comb begin
        best_d    = best_q;
        fits      = (cand_rate_i <= target_i);
        dist_cand = target_i - cand_rate_i;
        dist_best = target_i - best_q.rate;
        if (clr_i) begin
            best_d = '0;
        end else if (upd_i && fits && (dist_cand < dist_best)) begin
            best_d.rate = cand_rate_i;
            best_d.m    = cand_m_i;
            best_d.n    = cand_n_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) best_q <= '0;
        else         best_q <= best_d;
    end

    assign best_rate_o = best_q.rate;
    assign best_m_o    = best_q.m;
    assign best_n_o    = best_q.n;

    assert_best_not_above_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |-> (best_q.rate <= target_i));

    assert_best_never_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (best_q.rate >= $past(best_q.rate)));

    assert_tie_keeps_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && !clr_i && cand_rate_i == best_q.rate) |=> $stable(best_q));

endmodule

// File: rtl/rate_search_engine.sv
module rate_search_engine
    import rate_search_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int PRE_W   = 8,
    parameter int OFF_W   = 8,
    parameter int CODE_W  = 3,
    parameter int DEC_DIV = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [RATE_W-1:0] parent_rate_i,
    input  logic [RATE_W-1:0] target_rate_i,
    input  logic [PRE_W-1:0]  prediv_i,
    input  logic [OFF_W-1:0]  m_offset_i,
    output logic [CODE_W-1:0] m_code_o,
    output logic [CODE_W-1:0] n_code_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        eng_state_e        st;
        eng_phase_e        ph;
        logic [CODE_W-1:0] m;
        logic [CODE_W-1:0] n;
        logic [RATE_W-1:0] parent;
        logic [RATE_W-1:0] target;
        logic [PRE_W-1:0]  pre;
        logic [OFF_W-1:0]  off;
        logic [RATE_W-1:0] base;
        logic              err;
    } eng_regs_t;

    eng_regs_t eng_d, eng_q;

    logic              div_go, div_done, div_dz;
    logic [RATE_W-1:0] div_dvd, div_dvs, div_quo;
    logic              keep_clr, keep_upd;

    always_comb begin
        eng_d    = eng_q;
        div_go   = 1'b0;
        div_dvd  = '0;
        div_dvs  = '0;
        keep_clr = 1'b0;
        keep_upd = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    eng_d.parent = parent_rate_i;
                    eng_d.target = target_rate_i;
                    eng_d.pre    = prediv_i;
                    eng_d.off    = m_offset_i;
                    eng_d.err    = 1'b0;
                    eng_d.ph     = PH_PRE;
                    eng_d.st     = ST_ISSUE;
                    keep_clr     = 1'b1;
                end
            end
            ST_ISSUE: begin
                div_go = 1'b1;
                unique case (eng_q.ph)
                    PH_PRE: begin
                        div_dvd = eng_q.parent;
                        div_dvs = RATE_W'(eng_q.pre);
                    end
                    PH_DEC: begin
                        div_dvd = eng_q.base;
                        div_dvs = RATE_W'(DEC_DIV);
                    end
                    default: begin
                        div_dvd = eng_q.base >> eng_q.n;
                        div_dvs = RATE_W'(eng_q.off) + RATE_W'(eng_q.m);
                    end
                endcase
                eng_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_done) begin
                    unique case (eng_q.ph)
                        PH_PRE: begin
                            if (div_dz) begin
                                eng_d.err = 1'b1;
                                eng_d.st  = ST_FIN;
                            end else begin
                                eng_d.base = div_quo;
                                eng_d.ph   = PH_DEC;
                                eng_d.st   = ST_ISSUE;
                            end
                        end
                        PH_DEC: begin
                            eng_d.base = div_quo;
                            eng_d.ph   = PH_CAND;
                            eng_d.m    = '0;
                            eng_d.n    = '0;
                            eng_d.st   = ST_ISSUE;
                        end
                        default: begin
                            if (div_dz) eng_d.err = 1'b1;
                            else        keep_upd  = 1'b1;
                            if (eng_q.m == CODE_MAX && eng_q.n == CODE_MAX) begin
                                eng_d.st = ST_FIN;
                            end else begin
                                if (eng_q.n == CODE_MAX) begin
                                    eng_d.n = '0;
                                    eng_d.m = eng_q.m + 1'b1;
                                end else begin
                                    eng_d.n = eng_q.n + 1'b1;
                                end
                                eng_d.st = ST_ISSUE;
                            end
                        end
                    endcase
                end
            end
            default: begin
                eng_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
            eng_q.ph <= PH_PRE;
        end else begin
            eng_q <= eng_d;
        end
    end

    rse_divider #(.W(RATE_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (div_go),
        .dvd_i  (div_dvd),
        .dvs_i  (div_dvs),
        .done_o (div_done),
        .dz_o   (div_dz),
        .quo_o  (div_quo)
    );

    rse_best_keeper #(.RATE_W(RATE_W), .CODE_W(CODE_W)) u_keep (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (keep_clr),
        .upd_i       (keep_upd),
        .target_i    (eng_q.target),
        .cand_rate_i (div_quo),
        .cand_m_i    (eng_q.m),
        .cand_n_i    (eng_q.n),
        .best_rate_o (rate_o),
        .best_m_o    (m_code_o),
        .best_n_o    (n_code_o)
    );

    assign done_o = (eng_q.st == ST_FIN);
    assign err_o  = eng_q.err;

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_ops_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st != ST_IDLE) |=> $stable(eng_q.target) && $stable(eng_q.off));

    assert_err_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o) |-> (eng_q.pre == '0 || eng_q.off == '0));

    assert_prediv_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && eng_q.pre == '0) |-> (err_o && rate_o == '0));

    assert_grid_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_WAIT && eng_q.ph == PH_CAND && div_done && eng_q.n != CODE_MAX)
        |=> (eng_q.n == $past(eng_q.n) + 1'b1) && $stable(eng_q.m));

endmodule

// File: tb/rate_search_engine_tb.sv
`timescale 1ns/1ps
module rate_search_engine_tb;

    typedef struct {
        logic [2:0]  m;
        logic [2:0]  n;
        logic [31:0] rate;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] parent = '0, target = '0;
    logic [7:0]  pre = '0, off = '0;
    logic [2:0]  m_code, n_code;
    logic [31:0] rate;
    logic        done, err;

    int checks = 0, errors = 0, seen = 0, sent = 0, cycles = 0;
    exp_t expq[$];
    logic prev_done = 1'b0;

    always #2 clk = ~clk;

    rate_search_engine u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .parent_rate_i(parent), .target_rate_i(target),
        .prediv_i(pre), .m_offset_i(off),
        .m_code_o(m_code), .n_code_o(n_code), .rate_o(rate),
        .done_o(done), .err_o(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] p, t, input logic [7:0] pd, of);
        exp_t e;
        logic [31:0] base, c, den;
        e.m = 0; e.n = 0; e.rate = 0; e.err = 0; e.tag = "";
        if (pd == 0) begin
            e.err = 1;
            return e;
        end
        base = (p / {24'd0, pd}) / 32'd10;
        for (int mm = 0; mm < 8; mm++) begin
            for (int nn = 0; nn < 8; nn++) begin
                den = 32'(of) + 32'(mm);
                if (den == 0) begin
                    e.err = 1;
                    continue;
                end
                c = (base >> nn) / den;
                if (c > t) continue;
                if ((t - c) < (t - e.rate)) begin
                    e.rate = c; e.m = 3'(mm); e.n = 3'(nn);
                end
            end
        end
        return e;
    endfunction

    // monitor: pops one expectation per done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done)
                check(0, "R7", "done longer than one cycle", 2, 1);
            if (done) begin
                if (expq.size() == 0) begin
                    check(0, "R6", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(rate == e.rate, e.tag, "rate (R1 R3)", rate, e.rate);
                    check(m_code == e.m, e.tag, "M code (R2 R4)", m_code, e.m);
                    check(n_code == e.n, e.tag, "N code (R2 R4)", n_code, e.n);
                    check(err == e.err, e.tag, "err flag (R10)", err, e.err);
                end
                seen++;
            end
            prev_done <= done;
        end
    end

    task automatic run_case(input logic [31:0] p, t, input logic [7:0] pd, of,
                            input string tag, input bit poke);
        exp_t e;
        e = model(p, t, pd, of);
        e.tag = tag;
        expq.push_back(e);
        sent++;
        @(negedge clk);
        parent = p; target = t; pre = pd; off = of; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            parent = ~p; target = t ^ 32'h5a5a; pre = pd + 8'd3; off = of + 8'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (seen < sent) @(negedge clk);
        repeat (3) @(negedge clk);
        check(rate == e.rate && m_code == e.m && n_code == e.n && !done, "R7",
              "result held after done", rate, e.rate);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL R7 watchdog actual=no-done expected=done");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        check(done == 0 && err == 0 && rate == 0 && m_code == 0 && n_code == 0,
              "R7", "reset state", rate, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(32'd24_000_000, 32'd100_000, 8'd1, 8'd1, "R1", 0);
        run_case(32'd1000, 32'd50, 8'd1, 8'd1, "R4", 0);          // tie: M0N1 vs M1N0
        run_case(32'd24_000_000, 32'd1000, 8'd2, 8'd1, "R5", 0);  // below smallest
        run_case(32'd24_000_000, 32'hffff_ffff, 8'd3, 8'd2, "R3", 0);
        run_case(32'd24_000_000, 32'd0, 8'd1, 8'd1, "R5", 0);
        run_case(32'd5, 32'd7, 8'd1, 8'd1, "R5", 0);               // all candidates 0
        run_case(32'd99_999, 32'd333, 8'd7, 8'd4, "R2", 0);
        run_case(32'd1_000_000, 32'd123, 8'd0, 8'd1, "R8", 0);
        run_case(32'd5000, 32'd300, 8'd1, 8'd0, "R9", 0);
        run_case(32'd5000, 32'd600, 8'd1, 8'd0, "R9", 0);
        run_case(32'd12_345_678, 32'd4321, 8'd2, 8'd3, "R6", 1);
        run_case(32'd80_000, 32'd1000, 8'd1, 8'd4, "R4", 0);       // many equal rates

        lfsr = 32'hace1_2345;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] p, t;
            logic [7:0]  pd, of;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            p = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            t = lfsr >> (8 + (i % 16));
            pd = 8'(lfsr[7:0] | 8'd1);
            of = 8'(lfsr[15:8] % 8);
            run_case(p, t, pd, of, "R1", 0);
        end

        repeat (5) @(negedge clk);
        check(expq.size() == 0 && seen == sent, "R6", "done count", seen, sent);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule